// File: doc/BRIEF.md
# Triggered Circular Sample FIFO

This block stores converter results in a circular buffer of fixed depth and raises a data-available interrupt when a programmed number of samples has arrived. The write side takes one sample per cycle from a conversion sequencer. The read side gives the host one word per read request. With each word the host also gets the buffer's empty and full state as it was when the request was sampled. The same empty and full state, together with the occupancy, is always visible on separate status outputs.

The block groups incoming samples into sets, and each set is `cfg_level` samples long. When the last sample of a set is written, the interrupt rises. What happens next depends on `cfg_cont`. In single-shot mode (`cfg_cont`=0) the block waits for the host. The first read after the trigger clears the interrupt and pulses `conv_start` to start the next set. In continuous mode (`cfg_cont`=1) `conv_start` pulses at once. The interrupt then clears on the next write or the next read, whichever comes first.

A trigger pointer marks where each set starts in the buffer. When the buffer is full, a new sample overwrites the oldest entry and the read position moves forward past it.

Top module: `trig_sample_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it, `stat_count`=0, `stat_empty`=1, `stat_full`=0, `dav_irq`=0 and `trig_ptr`=0. On the first clock edge with `rst_n` high, `conv_start` goes high for exactly one cycle.
- R2: Samples are read back in the order they were written. `stat_count` follows writes minus successful reads and never exceeds DEPTH.
- R3: `dav_irq` goes high right after the clock edge at which the write that completes a set of `cfg_level` samples is taken.
- R4: In single-shot mode, once the trigger has fired, `conv_start` stays low until a read request arrives. Writes during this wait do not count toward a set and do not change `dav_irq`.
- R5: In single-shot mode, the first read request after the trigger clears `dav_irq` and pulses `conv_start` at the same edge.
- R6: `trig_ptr` moves forward by `cfg_level`, modulo DEPTH, every time a new set starts. The set that starts on leaving reset does not move it.
- R7: In continuous mode, `conv_start` pulses at the same edge at which `dav_irq` rises.
- R8: In continuous mode, `dav_irq` clears at the next write or read request, whichever comes first. The one exception: a write that itself completes another set keeps `dav_irq` high.
- R9: A read request while the buffer is empty leaves the read position, `stat_count` and `rd_data` unchanged.
- R10: A write while the buffer is full overwrites the oldest entry and `stat_count` stays at DEPTH. The following read returns the second-oldest sample.
- R11: On each read request, `rd_was_empty` and `rd_was_full` show the buffer's empty and full state from the cycle in which the request was sampled.
- R12: A read and a write in the same cycle are both carried out. When the buffer is full, the read position moves forward by exactly one and `stat_count` stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cont | input | 1 | 1 = continuous mode, 0 = single-shot mode |
| cfg_level | input | AW+1 | Samples per set, from 1 to DEPTH |
| smp_valid | input | 1 | Write strobe from the sequencer |
| smp_data | input | DW | Sample to store |
| conv_start | output | 1 | One-cycle pulse that starts a new conversion set |
| rd_req | input | 1 | Host read request |
| rd_data | output | DW | Word returned by the last successful read |
| rd_was_empty | output | 1 | Buffer was empty when the last request was sampled |
| rd_was_full | output | 1 | Buffer was full when the last request was sampled |
| stat_empty | output | 1 | Buffer is empty now |
| stat_full | output | 1 | Buffer is full now |
| stat_count | output | AW+1 | Number of entries held |
| dav_irq | output | 1 | Data-available interrupt |
| trig_ptr | output | AW | Buffer position where the current set starts |

## Verification
A pointer off by one shows up at the first read after the fault. That read returns a neighbouring sample and breaks the write order. A set counter in the wrong state moves the `dav_irq` and `conv_start` edges by a whole cycle or more at the next trigger, and a wrong step size shows up as a wrong `trig_ptr` at that same edge. A broken overwrite rule only shows after the buffer has wrapped. It appears as a wrong `stat_count` or as a stale word on the read after the overflowing write, so the bench fills the buffer completely before it checks.

// File: rtl/tsf_pkg.sv
// Package: shared definitions for the triggered sample FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package tsf_pkg;

    // Mode selector values, taken from the cfg_cont pin
    typedef enum logic {
        TSF_SINGLE = 1'b0,
        TSF_CONT   = 1'b1
    } tsf_mode_e;

endpackage

// File: rtl/tsf_store.sv
// Module: tsf_store
// Circular storage with read and write positions and an occupancy count.
// A write into a full buffer overwrites the oldest entry and moves the read
// position along with it. A read from an empty buffer changes nothing. The
// empty and full state seen when a read is sampled is returned with the data.
// Assumes: DEPTH is a power of two, so the positions wrap naturally.
module tsf_store #(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_was_empty,
    output logic          rd_was_full,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_pos;
    logic [AW-1:0] rd_pos;
    logic [CW-1:0] cnt;
    logic          take;      // read that actually returns a word
    logic          overrun;   // write that lands on the oldest entry

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign count   = cnt;
    assign take    = rd_en && !empty;
    assign overrun = wr_en && full;

    // Store each incoming sample at the write position
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_pos] <= wr_data;
    end

    // Move the read and write positions forward; the read position moves at most one step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pos <= '0;
            rd_pos <= '0;
        end else begin
            if (wr_en)
                wr_pos <= wr_pos + 1'b1;
            if (take || overrun)
                rd_pos <= rd_pos + 1'b1;
        end
    end

    // Keep the occupancy; an overrun holds it at the full value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (overrun)
            cnt <= cnt;
        else if (wr_en && !take)
            cnt <= cnt + 1'b1;
        else if (take && !wr_en)
            cnt <= cnt - 1'b1;
    end

    // Latch the returned word and the flags that go with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data      <= '0;
            rd_was_empty <= 1'b0;
            rd_was_full  <= 1'b0;
        end else if (rd_en) begin
            if (take)
                rd_data <= mem[rd_pos];
            rd_was_empty <= empty;
            rd_was_full  <= full;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (cnt == '0 && $stable(rd_pos) && $stable(rd_data)));

    assert_full_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> (full && rd_pos == $past(rd_pos) + 1'b1));

    assert_flags_with_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_was_empty == $past(empty) && rd_was_full == $past(full)));

endmodule

// File: rtl/tsf_trigger.sv
// Module: tsf_trigger
// Counts the samples of the current set and fires a trigger when the count
// reaches the programmed level. It drives the interrupt, the pulse that starts
// the next conversion set and the trigger pointer, in either mode.
// Assumes: level is between 1 and DEPTH and does not change while sets run.
module tsf_trigger
    import tsf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tsf_mode_e     mode,
    input  logic [CW-1:0] level,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          irq,
    output logic          conv_start,
    output logic [AW-1:0] trig_ptr
);

    logic          boot;      // first cycle after reset: start the first set
    logic          waiting;   // single-shot: trigger fired, host not yet reading
    logic [CW-1:0] set_cnt;
    logic          trig;
    logic          release_s; // single-shot: read that restarts conversion
    logic          restart;   // a new set begins at this edge (not the first one)

    assign trig      = wr_en && !waiting && (set_cnt + 1'b1 == level);
    assign release_s = (mode == TSF_SINGLE) && waiting && rd_en;
    assign restart   = ((mode == TSF_CONT) && trig) || release_s;

    // Count the writes that belong to the running set
    always_ff @(posedge clk) begin
        if (!rst_n)
            set_cnt <= '0;
        else if (trig)
            set_cnt <= '0;
        else if (wr_en && !waiting)
            set_cnt <= set_cnt + 1'b1;
    end

    // Single-shot wait state: entered at the trigger, left at the host's first read
    always_ff @(posedge clk) begin
        if (!rst_n)
            waiting <= 1'b0;
        else if (mode == TSF_SINGLE && trig)
            waiting <= 1'b1;
        else if (release_s)
            waiting <= 1'b0;
    end

    // Start pulse: once after reset, then at every restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot       <= 1'b1;
            conv_start <= 1'b0;
        end else begin
            boot       <= 1'b0;
            conv_start <= boot || restart;
        end
    end

    // Interrupt: set by a trigger, cleared by the mode's own rule
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (trig)
            irq <= 1'b1;
        else if (mode == TSF_SINGLE && release_s)
            irq <= 1'b0;
        else if (mode == TSF_CONT && (wr_en || rd_en))
            irq <= 1'b0;
    end

    // Trigger pointer: moves forward by one set length at every restart
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_ptr <= '0;
        else if (restart)
            trig_ptr <= trig_ptr + AW'(level);
    end

    assert_irq_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_en));

    assert_single_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TSF_SINGLE && waiting && !rd_en) |=> !conv_start);

    assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TSF_SINGLE && waiting && rd_en) |=> (conv_start && !irq));

    assert_ptr_moves_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trig_ptr) |-> conv_start);

    assert_cont_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TSF_CONT && $rose(irq)) |-> conv_start);

    assert_cont_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TSF_CONT && irq && rd_en && !wr_en) |=> !irq);

endmodule

// File: rtl/trig_sample_fifo.sv
// Module: trig_sample_fifo (top)
// Triggered circular sample FIFO: storage with overwrite-on-full, plus
// set counting with a mode-dependent interrupt and conversion restart.
// Assumes: DEPTH is a power of two; cfg_level is in 1..DEPTH; the mode and
// level are set while the block is in reset and stay fixed afterwards.
module trig_sample_fifo
    import tsf_pkg::*;
#(
    parameter int DW    = 12,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_cont,
    input  logic [CW-1:0] cfg_level,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          conv_start,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_was_empty,
    output logic          rd_was_full,
    output logic          stat_empty,
    output logic          stat_full,
    output logic [CW-1:0] stat_count,
    output logic          dav_irq,
    output logic [AW-1:0] trig_ptr
);

    tsf_mode_e mode;

    assign mode = cfg_cont ? TSF_CONT : TSF_SINGLE;

    tsf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (smp_valid),
        .wr_data      (smp_data),
        .rd_en        (rd_req),
        .rd_data      (rd_data),
        .rd_was_empty (rd_was_empty),
        .rd_was_full  (rd_was_full),
        .count        (stat_count),
        .empty        (stat_empty),
        .full         (stat_full)
    );

    tsf_trigger #(.DEPTH(DEPTH)) u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .level      (cfg_level),
        .wr_en      (smp_valid),
        .rd_en      (rd_req),
        .irq        (dav_irq),
        .conv_start (conv_start),
        .trig_ptr   (trig_ptr)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stat_count == '0 && !dav_irq && trig_ptr == '0));

endmodule

// File: tb/tb_trig_sample_fifo.sv
// Bench for trig_sample_fifo: a table of vectors in continuous mode, then
// directed tests for reset, single-shot mode, empty reads, the full buffer
// and a set length of one.
module tb_trig_sample_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cont = 1'b1;
    logic [4:0]  cfg_level = 5'd3;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        rd_req = 1'b0;
    logic        conv_start, rd_was_empty, rd_was_full, stat_empty, stat_full, dav_irq;
    logic [11:0] rd_data;
    logic [4:0]  stat_count;
    logic [3:0]  trig_ptr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    trig_sample_fifo dut (
        .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_level(cfg_level),
        .smp_valid(smp_valid), .smp_data(smp_data), .conv_start(conv_start),
        .rd_req(rd_req), .rd_data(rd_data), .rd_was_empty(rd_was_empty),
        .rd_was_full(rd_was_full), .stat_empty(stat_empty), .stat_full(stat_full),
        .stat_count(stat_count), .dav_irq(dav_irq), .trig_ptr(trig_ptr)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] dat;
        logic        rd;
        logic [4:0]  cnt;
        logic        irq;
        logic        st;
        logic [3:0]  tp;
        logic        chk;
        logic [11:0] rdat;
    } vec_t;

    // Continuous mode, three samples per set
    localparam vec_t TABLE [10] = '{
        '{1'b1, 12'hA01, 1'b0, 5'd1, 1'b0, 1'b0, 4'd0, 1'b0, 12'h000},
        '{1'b1, 12'hA02, 1'b0, 5'd2, 1'b0, 1'b0, 4'd0, 1'b0, 12'h000},
        '{1'b1, 12'hA03, 1'b0, 5'd3, 1'b1, 1'b1, 4'd3, 1'b0, 12'h000},
        '{1'b1, 12'hA04, 1'b0, 5'd4, 1'b0, 1'b0, 4'd3, 1'b0, 12'h000},
        '{1'b1, 12'hA05, 1'b0, 5'd5, 1'b0, 1'b0, 4'd3, 1'b0, 12'h000},
        '{1'b1, 12'hA06, 1'b0, 5'd6, 1'b1, 1'b1, 4'd6, 1'b0, 12'h000},
        '{1'b0, 12'h000, 1'b1, 5'd5, 1'b0, 1'b0, 4'd6, 1'b1, 12'hA01},
        '{1'b1, 12'hA07, 1'b1, 5'd5, 1'b0, 1'b0, 4'd6, 1'b1, 12'hA02},
        '{1'b0, 12'h000, 1'b0, 5'd5, 1'b0, 1'b0, 4'd6, 1'b0, 12'h000},
        '{1'b0, 12'h000, 1'b1, 5'd4, 1'b0, 1'b0, 4'd6, 1'b1, 12'hA03}
    };

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Inputs are applied at a negedge, taken at the posedge and checked at the next negedge
    task automatic step(input logic wr, input logic [11:0] d, input logic rd);
        smp_valid = wr;
        smp_data  = d;
        rd_req    = rd;
        @(negedge clk);
        smp_valid = 1'b0;
        rd_req    = 1'b0;
    endtask

    task automatic do_reset(input logic cont, input logic [4:0] lvl);
        rst_n     = 1'b0;
        cfg_cont  = cont;
        cfg_level = lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start pulse after reset", conv_start, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 count", stat_count, 0);
        chk("R1 empty", stat_empty, 1);
        chk("R1 full", stat_full, 0);
        chk("R1 irq", dav_irq, 0);
        chk("R1 trig_ptr", trig_ptr, 0);
        chk("R1 no start during reset", conv_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start pulse", conv_start, 1);
        @(negedge clk);
        chk("R1 start pulse one cycle", conv_start, 0);

        // Table: R2 R3 R6 R7 R8 R12
        foreach (TABLE[i]) begin
            step(TABLE[i].wr, TABLE[i].dat, TABLE[i].rd);
            chk("R2 count", stat_count, TABLE[i].cnt);
            chk("R3/R8 irq", dav_irq, TABLE[i].irq);
            chk("R7 start", conv_start, TABLE[i].st);
            chk("R6 trig_ptr", trig_ptr, TABLE[i].tp);
            if (TABLE[i].chk)
                chk("R2/R12 read order", rd_data, TABLE[i].rdat);
        end

        // Single-shot mode, two samples per set: R4 R5 R6
        do_reset(1'b0, 5'd2);
        step(1'b1, 12'd11, 1'b0);
        chk("R3 no irq mid-set", dav_irq, 0);
        step(1'b1, 12'd12, 1'b0);
        chk("R3 irq at level", dav_irq, 1);
        chk("R4 no start at single trigger", conv_start, 0);
        step(1'b1, 12'd13, 1'b0);
        chk("R4 irq kept during wait", dav_irq, 1);
        chk("R4 no start on write during wait", conv_start, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 no start without read", conv_start, 0);
        end
        step(1'b0, 12'd0, 1'b1);
        chk("R5 irq cleared by read", dav_irq, 0);
        chk("R5 start on read", conv_start, 1);
        chk("R6 trig_ptr single", trig_ptr, 2);
        chk("R5 data", rd_data, 11);
        step(1'b1, 12'd14, 1'b0);
        chk("R4 wait writes not counted", dav_irq, 0);
        step(1'b1, 12'd15, 1'b0);
        chk("R3 second set irq", dav_irq, 1);
        chk("R6 ptr held until read", trig_ptr, 2);
        step(1'b0, 12'd0, 1'b1);
        chk("R6 trig_ptr second", trig_ptr, 4);
        chk("R2 order", rd_data, 12);

        // Empty reads: R9 R11 R12
        do_reset(1'b1, 5'd4);
        step(1'b0, 12'd0, 1'b1);
        chk("R11 was_empty", rd_was_empty, 1);
        chk("R9 count", stat_count, 0);
        step(1'b1, 12'd21, 1'b0);
        step(1'b0, 12'd0, 1'b1);
        chk("R9 read pointer not moved", rd_data, 21);
        chk("R11 was_empty clear", rd_was_empty, 0);
        step(1'b0, 12'd0, 1'b1);
        chk("R9 data held", rd_data, 21);
        chk("R9 count held", stat_count, 0);
        step(1'b1, 12'd22, 1'b1);
        chk("R12 write with empty read", stat_count, 1);
        step(1'b0, 12'd0, 1'b1);
        chk("R12 data", rd_data, 22);

        // Full buffer: R10 R11 R12
        do_reset(1'b1, 5'd16);
        for (int k = 0; k < 16; k++)
            step(1'b1, 12'(100 + k), 1'b0);
        chk("R10 full", stat_full, 1);
        chk("R3 irq at depth", dav_irq, 1);
        chk("R7 start at depth", conv_start, 1);
        chk("R6 ptr wraps", trig_ptr, 0);
        step(1'b1, 12'd116, 1'b0);
        chk("R10 count stays", stat_count, 16);
        chk("R8 write clears irq", dav_irq, 0);
        step(1'b0, 12'd0, 1'b1);
        chk("R10 oldest dropped", rd_data, 101);
        chk("R11 was_full", rd_was_full, 1);
        chk("R2 count after read", stat_count, 15);
        step(1'b1, 12'd117, 1'b0);
        step(1'b1, 12'd118, 1'b1);
        chk("R12 full read+write data", rd_data, 102);
        chk("R12 full count", stat_count, 16);
        step(1'b0, 12'd0, 1'b1);
        chk("R12 single step", rd_data, 103);

        // One sample per set: R8 exception
        do_reset(1'b1, 5'd1);
        step(1'b1, 12'd31, 1'b0);
        chk("R3 level one", dav_irq, 1);
        step(1'b1, 12'd32, 1'b0);
        chk("R8 retrigger keeps irq", dav_irq, 1);
        chk("R7 start again", conv_start, 1);
        chk("R6 ptr", trig_ptr, 2);
        @(negedge clk);
        chk("R8 idle keeps irq", dav_irq, 1);
        step(1'b0, 12'd0, 1'b1);
        chk("R8 read clears irq", dav_irq, 0);
        chk("R2 data", rd_data, 31);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule